// File: doc/BRIEF.md
# Nibble-Wide Link Port Transceiver

This block is one end of a point-to-point link between two processors. It moves whole words across a 4-bit data path. A strobe clock marks each nibble, and a return acknowledge line paces the words. A configuration bit sets the port to transmit or to receive, so two instances of the same block make a complete link. A word is either 32 or 48 bits wide. The link runs at one of two rates: one nibble per link clock period, or two.

On the transmit side, the host writes a word into a holding register. When the output shift register is free, the word moves into it, which leaves the holding register free for the next write while the first word is still on the wire. A word starts only while the far end's acknowledge is high. On the receive side, nibbles are gathered into an assembly register. A finished word passes to a receive holding register that the host reads. With both registers occupied, the receiver drops its acknowledge. Status outputs tell the host when a write or a read is possible. Dropping the enable clears every buffer.

Top module: `nib_link_port`

## Requirements
- R1: With the enable low, including straight after reset, `tx_empty`=1, `rx_full`=0, `lk_clk_o`=0 and `lk_ack_o`=0. Once the port is enabled in receive mode with empty buffers, `lk_ack_o` is 1.
- R2: Nibbles leave least-significant first. In the cycle where `lk_clk_o` first goes high for a word, `lk_dat_o` carries bits 3:0 of that word.
- R3: With `cfg_dbl`=0 the transmitter raises `lk_clk_o` for one cycle per nibble and lowers it for one cycle between nibbles, and the receiver takes a nibble on each rising edge. With `cfg_dbl`=1 `lk_clk_o` toggles every cycle and the receiver takes a nibble on every change.
- R4: With `cfg_wide`=0 a word is 8 nibbles and is delivered on `rd_data` with bits 47:32 zero. With `cfg_wide`=1 a word is 12 nibbles.
- R5: A write with `wr_en`=1 while `tx_empty`=1 is accepted, and `tx_empty` reads 0 in the next cycle. The holding register empties as soon as its word moves into the idle shifter, so a second word can be written while the first is still being sent. A write while `tx_empty`=0 is dropped.
- R6: Received words appear on `rd_data` with `rx_full`=1, in the order they were sent. A cycle with `rd_en`=1 removes the held word. `rd_en` while `rx_full`=0 has no effect.
- R7: The receiver drives `lk_ack_o` low while both its assembly register and its holding register contain a complete word. It drives it high again in the cycle after the host reads one.
- R8: The transmitter starts a word only while `lk_ack_i`=1. `lk_clk_o` stays low whenever no word is being sent.
- R9: Clearing `cfg_en` empties both buffers of both directions, drives `lk_clk_o` and `lk_ack_o` low, and discards any queued word.
- R10: `cfg_dir_tx`=1 selects transmit and `cfg_dir_tx`=0 selects receive. In receive mode, host writes have no effect and `lk_clk_o` stays low. In transmit mode, `lk_ack_o` stays low and `rx_full` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Port enable; low clears all buffers |
| cfg_dir_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_wide | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| cfg_dbl | input | 1 | 1 = two nibbles per link clock period |
| wr_en | input | 1 | Host write strobe for the transmit holding register |
| wr_data | input | 48 | Word to send (bits 31:0 used in 32-bit mode) |
| tx_empty | output | 1 | Transmit holding register can take a word |
| rd_en | input | 1 | Host read strobe for the receive holding register |
| rd_data | output | 48 | Oldest received word |
| rx_full | output | 1 | A received word is waiting |
| lk_clk_o | output | 1 | Link strobe clock driven when transmitting |
| lk_dat_o | output | 4 | Link nibble driven when transmitting |
| lk_ack_i | input | 1 | Acknowledge from the far receiver |
| lk_clk_i | input | 1 | Link strobe clock from the far transmitter |
| lk_dat_i | input | 4 | Link nibble from the far transmitter |
| lk_ack_o | output | 1 | Acknowledge to the far transmitter |

## Verification
The hardest state to reach is flow-control backpressure. Here the receiver holds two complete words with its acknowledge low, while the transmitter has a third word parked in its shifter and a fourth in its holding register. The bench links a transmit instance to a receive instance and holds back host reads while it queues four words, which fills every buffer on both sides. It then checks that the link clock stays silent, that an extra write is dropped, and that a single read brings the acknowledge back before draining the rest.

// File: rtl/nib_link_pkg.sv
package nib_link_pkg;
    parameter int unsigned NIB_W       = 4;
    parameter int unsigned WIDE_W      = 48;
    parameter int unsigned NARROW_W    = 32;
    localparam int unsigned WIDE_NIBS   = WIDE_W / NIB_W;
    localparam int unsigned NARROW_NIBS = NARROW_W / NIB_W;
    localparam int unsigned CNT_W       = $clog2(WIDE_NIBS + 1);

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_WAIT = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic en;
        logic dir_tx;
        logic wide;
        logic dbl;
    } link_cfg_t;

    function automatic logic [CNT_W-1:0] nibs_per_word(input logic wide);
        return wide ? CNT_W'(WIDE_NIBS) : CNT_W'(NARROW_NIBS);
    endfunction
endpackage

// File: rtl/nib_link_tx.sv
module nib_link_tx
    import nib_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic              wide,
    input  logic              dbl,
    input  logic              wr_en,
    input  logic [WIDE_W-1:0] wr_data,
    output logic              tx_empty,
    output logic              lk_clk_o,
    output logic [NIB_W-1:0]  lk_dat_o,
    input  logic              lk_ack_i
);
    tx_state_e         state;
    logic [WIDE_W-1:0] hold_q;
    logic              hold_full;
    logic [WIDE_W-1:0] sh_q;
    logic [CNT_W-1:0]  left_q;
    logic              clk_q;
    logic [NIB_W-1:0]  dat_q;
    logic [CNT_W-1:0]  last_idx;

    assign last_idx = nibs_per_word(wide) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            state     <= TX_IDLE;
            hold_q    <= '0;
            hold_full <= 1'b0;
            sh_q      <= '0;
            left_q    <= '0;
            clk_q     <= 1'b0;
            dat_q     <= '0;
        end else begin
            if (wr_en && !hold_full) begin
                hold_q    <= wr_data;
                hold_full <= 1'b1;
            end
            case (state)
                TX_IDLE: begin
                    if (hold_full) begin
                        sh_q      <= hold_q;
                        hold_full <= 1'b0;
                        state     <= TX_WAIT;
                    end
                end
                TX_WAIT: begin
                    if (lk_ack_i) begin
                        clk_q  <= 1'b1;
                        dat_q  <= sh_q[NIB_W-1:0];
                        sh_q   <= sh_q >> NIB_W;
                        left_q <= last_idx;
                        state  <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (!dbl && clk_q) begin
                        clk_q <= 1'b0;
                        if (left_q == '0) state <= TX_IDLE;
                    end else if (left_q == '0) begin
                        clk_q <= 1'b0;
                        state <= TX_IDLE;
                    end else begin
                        clk_q  <= dbl ? ~clk_q : 1'b1;
                        dat_q  <= sh_q[NIB_W-1:0];
                        sh_q   <= sh_q >> NIB_W;
                        left_q <= left_q - CNT_W'(1);
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign tx_empty = !hold_full;
    assign lk_clk_o = clk_q;
    assign lk_dat_o = dat_q;

    AST_WAIT_FOR_ACK: assert property (@(posedge clk) disable iff (rst)
        (act && state == TX_WAIT && !lk_ack_i) |=> !lk_clk_o); // R8
    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        (state != TX_SEND) |-> !lk_clk_o); // R8
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        left_q < CNT_W'(WIDE_NIBS)); // R4
    AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (act && wr_en && tx_empty) |=> !tx_empty); // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !act |=> (!lk_clk_o && tx_empty)); // R9
endmodule

// File: rtl/nib_link_rx.sv
module nib_link_rx
    import nib_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic              wide,
    input  logic              dbl,
    input  logic              lk_clk_i,
    input  logic [NIB_W-1:0]  lk_dat_i,
    output logic              lk_ack_o,
    input  logic              rd_en,
    output logic [WIDE_W-1:0] rd_data,
    output logic              rx_full
);
    logic              clk_prev;
    logic [WIDE_W-1:0] asm_q;
    logic [CNT_W-1:0]  asm_cnt;
    logic              asm_full;
    logic [WIDE_W-1:0] hold_q;
    logic              hold_full;
    logic              edge_seen;
    logic              take;
    logic              pop;
    logic [CNT_W-1:0]  last_idx;

    assign last_idx  = nibs_per_word(wide) - CNT_W'(1);
    assign edge_seen = dbl ? (lk_clk_i ^ clk_prev) : (lk_clk_i & ~clk_prev);
    assign take      = edge_seen && !asm_full;
    assign pop       = rd_en && hold_full;

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            clk_prev  <= 1'b0;
            asm_q     <= '0;
            asm_cnt   <= '0;
            asm_full  <= 1'b0;
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else begin
            clk_prev <= lk_clk_i;
            if (take) begin
                for (int i = 0; i < WIDE_NIBS; i++) begin
                    if (asm_cnt == CNT_W'(i)) asm_q[i*NIB_W +: NIB_W] <= lk_dat_i;
                end
                if (asm_cnt == last_idx) begin
                    asm_full <= 1'b1;
                    asm_cnt  <= '0;
                end else begin
                    asm_cnt <= asm_cnt + CNT_W'(1);
                end
            end
            if (asm_full && (!hold_full || pop)) begin
                hold_q    <= asm_q;
                hold_full <= 1'b1;
                asm_full  <= 1'b0;
                asm_q     <= '0;
            end else if (pop) begin
                hold_full <= 1'b0;
            end
        end
    end

    assign lk_ack_o = act && !(asm_full && hold_full);
    assign rd_data  = hold_q;
    assign rx_full  = hold_full;

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (act && edge_seen) |-> !asm_full); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (act && hold_full && !rd_en) |=> (rx_full && $stable(rd_data))); // R6
    AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (rst)
        (act && rd_en && !hold_full && !asm_full) |=> !rx_full); // R6
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !act |=> !rx_full); // R9
endmodule

// File: rtl/nib_link_port.sv
module nib_link_port
    import nib_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_dir_tx,
    input  logic              cfg_wide,
    input  logic              cfg_dbl,
    input  logic              wr_en,
    input  logic [WIDE_W-1:0] wr_data,
    output logic              tx_empty,
    input  logic              rd_en,
    output logic [WIDE_W-1:0] rd_data,
    output logic              rx_full,
    output logic              lk_clk_o,
    output logic [NIB_W-1:0]  lk_dat_o,
    input  logic              lk_ack_i,
    input  logic              lk_clk_i,
    input  logic [NIB_W-1:0]  lk_dat_i,
    output logic              lk_ack_o
);
    link_cfg_t cfg;
    logic      tx_act;
    logic      rx_act;

    assign cfg    = '{en: cfg_en, dir_tx: cfg_dir_tx, wide: cfg_wide, dbl: cfg_dbl};
    assign tx_act = cfg.en && cfg.dir_tx;
    assign rx_act = cfg.en && !cfg.dir_tx;

    nib_link_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .act      (tx_act),
        .wide     (cfg.wide),
        .dbl      (cfg.dbl),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .tx_empty (tx_empty),
        .lk_clk_o (lk_clk_o),
        .lk_dat_o (lk_dat_o),
        .lk_ack_i (lk_ack_i)
    );

    nib_link_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .act      (rx_act),
        .wide     (cfg.wide),
        .dbl      (cfg.dbl),
        .lk_clk_i (lk_clk_i),
        .lk_dat_i (lk_dat_i),
        .lk_ack_o (lk_ack_o),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rx_full  (rx_full)
    );

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(lk_clk_o && lk_ack_o)); // R10
endmodule

// File: tb/nib_link_port_test.sv
module nib_link_port_test;
    import nib_link_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst = 1'b1, en_a = 1'b0, en_b = 1'b0, wide = 1'b0, dbl = 1'b0;
    logic              wr_en = 1'b0, p_wr = 1'b0, rd_en = 1'b0, u_rd = 1'b0;
    logic [WIDE_W-1:0] wr_data = '0;
    logic              u_tx_empty, u_clk, u_ack_o, u_rx_full;
    logic [NIB_W-1:0]  u_dat;
    logic [WIDE_W-1:0] u_rd_data;
    logic              p_tx_empty, p_clk_o, p_ack_o, p_rx_full;
    logic [NIB_W-1:0]  p_dat_o;
    logic [WIDE_W-1:0] p_rd_data;

    nib_link_port uut (
        .clk(clk), .rst(rst), .cfg_en(en_a), .cfg_dir_tx(1'b1), .cfg_wide(wide), .cfg_dbl(dbl),
        .wr_en(wr_en), .wr_data(wr_data), .tx_empty(u_tx_empty),
        .rd_en(u_rd), .rd_data(u_rd_data), .rx_full(u_rx_full),
        .lk_clk_o(u_clk), .lk_dat_o(u_dat), .lk_ack_i(p_ack_o),
        .lk_clk_i(p_clk_o), .lk_dat_i(p_dat_o), .lk_ack_o(u_ack_o)
    );

    nib_link_port peer (
        .clk(clk), .rst(rst), .cfg_en(en_b), .cfg_dir_tx(1'b0), .cfg_wide(wide), .cfg_dbl(dbl),
        .wr_en(p_wr), .wr_data(48'hABCD_EF01_2345), .tx_empty(p_tx_empty),
        .rd_en(rd_en), .rd_data(p_rd_data), .rx_full(p_rx_full),
        .lk_clk_o(p_clk_o), .lk_dat_o(p_dat_o), .lk_ack_i(1'b0),
        .lk_clk_i(u_clk), .lk_dat_i(u_dat), .lk_ack_o(p_ack_o)
    );

    int total = 0, bad = 0;
    bit done = 0;
    logic [WIDE_W-1:0] sbq[$];
    bit mon_on = 0, force_rd = 0;
    int grants = 0, used = 0;
    int highs = 0, toggles = 0, peer_highs = 0;
    logic clk_last = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [WIDE_W-1:0] got,
                       input logic [WIDE_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // link clock activity counters
    always @(negedge clk) begin
        if (u_clk != clk_last) toggles++;
        if (u_clk) highs++;
        if (p_clk_o) peer_highs++;
        clk_last = u_clk;
    end

    // scoreboard monitor: pops received words and compares them
    always @(negedge clk) begin
        if (p_rx_full && (mon_on || used < grants)) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R6 word with nothing expected", p_rd_data, '0);
            end else begin
                chk(p_rd_data == sbq[0], "R6/R4 received word", p_rd_data, sbq[0]);
                void'(sbq.pop_front());
            end
            if (!mon_on) used++;
            rd_en = 1'b1;
        end else begin
            rd_en = force_rd;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [WIDE_W-1:0] w);
        logic [WIDE_W-1:0] m;
        m = wide ? '1 : {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        while (!u_tx_empty) tick();
        wr_en   = 1'b1;
        wr_data = w;
        sbq.push_back(w & m);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && (sbq.size() != 0 || p_rx_full); i++) tick();
        repeat (20) tick();
        chk(sbq.size() == 0, "R6 all queued words delivered", 48'(sbq.size()), '0);
    endtask

    task automatic reconfig(input logic w, input logic d);
        en_a = 1'b0;
        en_b = 1'b0;
        tick();
        wide = w;
        dbl  = d;
        en_a = 1'b1;
        en_b = 1'b1;
        tick();
    endtask

    task automatic rate_case(input logic [WIDE_W-1:0] w, input int nibs);
        int h0, t0;
        h0 = highs;
        t0 = toggles;
        send(w);
        for (int i = 0; i < 20 && !u_clk; i++) tick();
        chk(u_dat == w[NIB_W-1:0], "R2 first nibble is bits 3:0", 48'(u_dat), 48'(w[NIB_W-1:0]));
        drain();
        chk(highs - h0 == (dbl ? nibs / 2 : nibs), "R3 link clock high cycles",
            48'(highs - h0), 48'(dbl ? nibs / 2 : nibs));
        chk(toggles - t0 == (dbl ? nibs : 2 * nibs), "R4 nibble count per word",
            48'(toggles - t0), 48'(dbl ? nibs : 2 * nibs));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int h0;
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1: reset state, port disabled
        chk(u_tx_empty == 1'b1, "R1 tx_empty after reset", 48'(u_tx_empty), 48'd1);
        chk(p_rx_full == 1'b0 && u_clk == 1'b0, "R1 rx_full/clk after reset", 48'({p_rx_full, u_clk}), '0);
        chk(p_ack_o == 1'b0, "R1 ack low while disabled", 48'(p_ack_o), '0);
        en_a = 1'b1;
        en_b = 1'b1;
        mon_on = 1;
        tick();
        chk(p_ack_o == 1'b1, "R1 ack high when receive enabled", 48'(p_ack_o), 48'd1);

        // R2 R3 R4: 32-bit, one nibble per period
        rate_case(48'hFFFF_1234_5679, 8);

        // R5: second word accepted while first is on the wire
        h0 = highs;
        send(48'h0000_A1B2_C3D4);
        chk(u_tx_empty == 1'b0, "R5 tx_empty low after write", 48'(u_tx_empty), '0);
        repeat (4) tick();
        chk(u_tx_empty == 1'b1 && highs - h0 < 8, "R5 holding freed mid-word",
            48'(u_tx_empty), 48'd1);
        send(48'h0000_0F0E_0D0C);
        chk(u_tx_empty == 1'b0, "R5 second write taken", 48'(u_tx_empty), '0);
        send(48'h0000_5555_AAAA);
        send(48'h0000_0000_0001);
        drain();

        // R3 R4: 48-bit, two nibbles per period
        reconfig(1'b1, 1'b1);
        rate_case(48'hFEDC_BA98_7654, 12);
        send(48'h8000_0000_0001);
        send(48'h1357_9BDF_2468);
        drain();

        // R7 R8 R5: backpressure with all buffers full
        mon_on = 0;
        send(48'h1111_2222_3333);
        send(48'h4444_5555_6666);
        send(48'h7777_8888_9999);
        send(48'hAAAA_BBBB_CCCC);
        repeat (40) tick();
        chk(p_rx_full == 1'b1, "R7 receiver holds a word", 48'(p_rx_full), 48'd1);
        chk(p_ack_o == 1'b0, "R7 ack low with both buffers full", 48'(p_ack_o), '0);
        chk(u_tx_empty == 1'b0, "R5 transmitter still holding", 48'(u_tx_empty), '0);
        h0 = highs;
        repeat (50) tick();
        chk(highs == h0, "R8 no link clock without ack", 48'(highs - h0), '0);
        wr_en   = 1'b1;
        wr_data = 48'h0BAD_0BAD_0BAD;
        tick();
        wr_en = 1'b0;
        grants++;
        @(negedge clk);
        @(negedge clk);
        chk(p_ack_o == 1'b1, "R7 ack back after one read", 48'(p_ack_o), 48'd1);
        tick();
        mon_on = 1;
        drain();

        // R6: read with nothing held
        mon_on   = 0;
        force_rd = 1;
        repeat (3) tick();
        force_rd = 0;
        tick();
        chk(p_rx_full == 1'b0 && p_ack_o == 1'b1, "R6 empty read has no effect",
            48'({p_rx_full, p_ack_o}), 48'h1);
        mon_on = 1;
        send(48'h0246_8ACE_1357);
        drain();

        // R10: direction selects which side drives
        h0 = peer_highs;
        p_wr = 1'b1;
        tick();
        p_wr = 1'b0;
        repeat (10) tick();
        chk(p_tx_empty == 1'b1 && peer_highs == h0, "R10 receive mode ignores writes",
            48'(p_tx_empty), 48'd1);
        chk(u_ack_o == 1'b0 && u_rx_full == 1'b0, "R10 transmit mode ack/rx low",
            48'({u_ack_o, u_rx_full}), '0);

        // R9: disable discards everything
        mon_on = 0;
        send(48'h1212_3434_5656);
        send(48'h7878_9A9A_BCBC);
        send(48'hDEDE_F0F0_1111);
        repeat (5) tick();
        en_a = 1'b0;
        en_b = 1'b0;
        tick();
        sbq.delete();
        chk(u_tx_empty == 1'b1 && u_clk == 1'b0, "R9 transmit side cleared",
            48'({u_tx_empty, u_clk}), 48'h2);
        chk(p_rx_full == 1'b0 && p_ack_o == 1'b0, "R9 receive side cleared",
            48'({p_rx_full, p_ack_o}), '0);
        en_a = 1'b1;
        en_b = 1'b1;
        tick();
        chk(p_rx_full == 1'b0 && p_ack_o == 1'b1, "R9 receiver empty after re-enable",
            48'({p_rx_full, p_ack_o}), 48'h1);
        mon_on = 1;
        send(48'h9876_5432_10FE);
        drain();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule